// File: doc/BRIEF.md
# DMA Address Translation and Permission Guard

This block stands in the path from I/O devices to memory and inspects every DMA access before it is allowed through. Each request names the issuing device, an I/O virtual address and whether it is a read or a write. A per-device configuration vector assigns each device a translation table. Several devices may be assigned the same table, and when they are they also share its cached translations. Tables are flat, with one entry per 4 KB page, and are held in a table memory reached through a single read port.

A small fully associative translation cache keeps recently used entries. On a hit the physical address is produced without touching the table memory. On a miss one table read is issued and the returned entry is used. Valid entries are then installed in the cache with round-robin replacement. An access whose page entry is not valid, or whose direction the entry does not allow, is terminated with a fault response and no address. Each such access raises a one-cycle fault pulse and records the device and address. Software that edits a table must pulse the flush input before the edit is guaranteed to be seen.

Top module: `dma_xlate_guard`

## Requirements
- R1: After reset `req_ready` is 1, while `rsp_valid`, `fault_pulse`, `tbl_rd_valid`, `fault_dev` and `fault_addr` are all 0.
- R2: The table for a device is the field `dev_map[dev*TID_W +: TID_W]`. Devices given the same table receive identical translations, and a page cached through one of them is a hit for the others.
- R3: An allowed access returns `rsp_fault`=0 and `rsp_pa` = {entry physical page number, the low 12 address bits}.
- R4: A read needs the entry's read bit and a write needs its write bit. Otherwise the response carries `rsp_fault`=1 and `rsp_pa`=0.
- R5: An access whose table entry has the valid bit clear gets a fault response.
- R6: An access to a page already held in the cache for the same table issues no table read.
- R7: A cache miss issues exactly one table read, at address {table id, address bits above bit 11}. Table entry layout: bit 14 valid, bit 13 read allowed, bit 12 write allowed, bits 11:0 physical page number.
- R8: A table change is not seen while the cache holds the old entry. After a `flush` pulse the next access reads the table again.
- R9: Every fault response raises `fault_pulse` for exactly its first response cycle and loads `fault_dev`/`fault_addr`. These registers keep their values until the next fault.
- R10: The cache holds 8 entries, filled in round-robin order starting from slot 0 after reset or flush. The ninth distinct page evicts the first.
- R11: Only one request is in flight. `req_ready` is 0 while a response is pending, and the response holds steady until `rsp_ready`.
- R12: Entries with the valid bit clear are never cached, so a later access to that page reads the table again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_map | input | NUM_DEV*TID_W | Table id per device, packed by device index |
| flush | input | 1 | Invalidate every cached translation |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can take a request |
| req_dev | input | DEV_W | Issuing device |
| req_iova | input | IOVA_W | I/O virtual address |
| req_write | input | 1 | 1 for write, 0 for read |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumed |
| rsp_pa | output | PA_W | Physical address, 0 on fault |
| rsp_fault | output | 1 | Access blocked |
| tbl_rd_valid | output | 1 | One-cycle table read strobe |
| tbl_rd_addr | output | TAG_W | Table memory address |
| tbl_rsp_valid | input | 1 | Table read data present |
| tbl_rsp_data | input | ENT_W | Table entry |
| fault_pulse | output | 1 | One-cycle fault indication |
| fault_dev | output | DEV_W | Device of the latest fault |
| fault_addr | output | IOVA_W | Address of the latest fault |

## Verification
The properties assume that the table memory answers each read strobe exactly once, after the strobe, and never on its own. They also assume that `dev_map` stays constant while requests are in flight. The bench's memory model answers each strobe after two cycles, holds the device map fixed for the whole run, and pulses flush only while no request is pending. Requests are presented one at a time and held until accepted. Back-pressure on the response side is applied on purpose, so that response stability is exercised.

// File: rtl/dxg_pkg.sv
// Shared definitions for the DMA translation guard.
// Assumes table entries are laid out as {valid, read_ok, write_ok, ppn}.
package dxg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_WAIT = 2'd2,
        ST_RESP = 2'd3
    } dxg_state_e;

    // Returns 1 when the entry's permission bits allow the access direction.
    function automatic logic perm_ok(input logic rd_ok, input logic wr_ok, input logic is_write);
        return is_write ? wr_ok : rd_ok;
    endfunction

endpackage

// File: rtl/dxg_tlb.sv
// Fully associative translation cache with round-robin fill.
// Assumes fill_en only when the entry is valid; flush clears all slots and
// rewinds the fill pointer to slot 0 in one cycle.
module dxg_tlb #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 10,
    parameter int PPN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             hit,
    output logic [PPN_W-1:0] hit_ppn,
    output logic             hit_rd,
    output logic             hit_wr,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_rd,
    input  logic             fill_wr
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PTR_W-1:0] ptr;
    logic [DEPTH-1:0] match;
    logic [PPN_W-1:0] ppn_m [DEPTH];
    logic [DEPTH-1:0] rd_m;
    logic [DEPTH-1:0] wr_m;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic             e_vld;
        logic [TAG_W-1:0] e_tag;
        logic [PPN_W-1:0] e_ppn;
        logic             e_rd;
        logic             e_wr;
        logic             e_sel;

        assign e_sel = fill_en && (ptr == PTR_W'(g));

        // Slot storage: cleared by reset or flush, loaded when selected for fill.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                e_vld <= 1'b0;
                e_tag <= '0;
                e_ppn <= '0;
                e_rd  <= 1'b0;
                e_wr  <= 1'b0;
            end else if (e_sel) begin
                e_vld <= 1'b1;
                e_tag <= fill_tag;
                e_ppn <= fill_ppn;
                e_rd  <= fill_rd;
                e_wr  <= fill_wr;
            end
        end

        assign match[g] = e_vld && (e_tag == lk_tag);
        assign ppn_m[g] = match[g] ? e_ppn : '0;
        assign rd_m[g]  = match[g] && e_rd;
        assign wr_m[g]  = match[g] && e_wr;
    end

    // Merge the (at most one) matching slot onto the hit outputs.
    always_comb begin
        hit_ppn = '0;
        for (int i = 0; i < DEPTH; i++) begin
            hit_ppn = hit_ppn | ppn_m[i];
        end
        hit    = |match;
        hit_rd = |rd_m;
        hit_wr = |wr_m;
    end

    // Round-robin fill pointer; rewinds on flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ptr <= '0;
        end else if (fill_en) begin
            ptr <= (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/dxg_fault_log.sv
// Fault reporter: one-cycle pulse plus sticky device/address capture.
// Assumes log_en is high for one cycle per blocked access.
module dxg_fault_log #(
    parameter int DEV_W  = 3,
    parameter int IOVA_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              log_en,
    input  logic [DEV_W-1:0]  log_dev,
    input  logic [IOVA_W-1:0] log_addr,
    output logic              fault_pulse,
    output logic [DEV_W-1:0]  fault_dev,
    output logic [IOVA_W-1:0] fault_addr
);
    // Register the pulse and capture the offending request on each fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_pulse <= 1'b0;
            fault_dev   <= '0;
            fault_addr  <= '0;
        end else begin
            fault_pulse <= log_en;
            if (log_en) begin
                fault_dev  <= log_dev;
                fault_addr <= log_addr;
            end
        end
    end

endmodule

// File: rtl/dma_xlate_guard.sv
// DMA address translation and permission guard.
// Takes one request at a time: looks it up in the cache, on a miss reads one
// flat table entry, then returns a translated address or a fault.
// Assumes the table memory answers each read strobe exactly once and that
// dev_map is static while requests are in flight.
module dma_xlate_guard
    import dxg_pkg::*;
#(
    parameter int NUM_DEV    = 8,
    parameter int NUM_TBL    = 4,
    parameter int IOVA_W     = 20,
    parameter int PA_W       = 24,
    parameter int PAGE_SHIFT = 12,
    parameter int TLB_DEPTH  = 8,
    localparam int DEV_W     = $clog2(NUM_DEV),
    localparam int TID_W     = $clog2(NUM_TBL),
    localparam int VPN_W     = IOVA_W - PAGE_SHIFT,
    localparam int PPN_W     = PA_W - PAGE_SHIFT,
    localparam int TAG_W     = TID_W + VPN_W,
    localparam int ENT_W     = PPN_W + 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_DEV*TID_W-1:0] dev_map,
    input  logic                     flush,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [DEV_W-1:0]         req_dev,
    input  logic [IOVA_W-1:0]        req_iova,
    input  logic                     req_write,
    output logic                     rsp_valid,
    input  logic                     rsp_ready,
    output logic [PA_W-1:0]          rsp_pa,
    output logic                     rsp_fault,
    output logic                     tbl_rd_valid,
    output logic [TAG_W-1:0]         tbl_rd_addr,
    input  logic                     tbl_rsp_valid,
    input  logic [ENT_W-1:0]         tbl_rsp_data,
    output logic                     fault_pulse,
    output logic [DEV_W-1:0]         fault_dev,
    output logic [IOVA_W-1:0]        fault_addr
);
    dxg_state_e         state, nxt;
    logic [DEV_W-1:0]   cur_dev;
    logic [IOVA_W-1:0]  cur_iova;
    logic               cur_wr;
    logic [TID_W-1:0]   cur_tid;
    logic [PA_W-1:0]    pa_q;
    logic               flt_q;
    logic [TAG_W-1:0]   cur_tag;
    logic               hit, hit_rd, hit_wr;
    logic [PPN_W-1:0]   hit_ppn;
    logic               fill_en, log_en, ld_res, res_fault;
    logic [PA_W-1:0]    res_pa;
    logic               ent_v, ent_r, ent_w;
    logic [PPN_W-1:0]   ent_ppn;

    assign cur_tag     = {cur_tid, cur_iova[IOVA_W-1:PAGE_SHIFT]};
    assign tbl_rd_addr = cur_tag;
    assign req_ready   = (state == ST_IDLE);
    assign rsp_valid   = (state == ST_RESP);
    assign rsp_pa      = pa_q;
    assign rsp_fault   = flt_q;
    assign ent_v       = tbl_rsp_data[ENT_W-1];
    assign ent_r       = tbl_rsp_data[ENT_W-2];
    assign ent_w       = tbl_rsp_data[ENT_W-3];
    assign ent_ppn     = tbl_rsp_data[PPN_W-1:0];

    dxg_tlb #(.DEPTH(TLB_DEPTH), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .lk_tag   (cur_tag),
        .hit      (hit),
        .hit_ppn  (hit_ppn),
        .hit_rd   (hit_rd),
        .hit_wr   (hit_wr),
        .fill_en  (fill_en),
        .fill_tag (cur_tag),
        .fill_ppn (ent_ppn),
        .fill_rd  (ent_r),
        .fill_wr  (ent_w)
    );

    dxg_fault_log #(.DEV_W(DEV_W), .IOVA_W(IOVA_W)) u_flog (
        .clk         (clk),
        .rst_n       (rst_n),
        .log_en      (log_en),
        .log_dev     (cur_dev),
        .log_addr    (cur_iova),
        .fault_pulse (fault_pulse),
        .fault_dev   (fault_dev),
        .fault_addr  (fault_addr)
    );

    // Sequencing and result selection for the request in flight.
    always_comb begin
        nxt          = state;
        tbl_rd_valid = 1'b0;
        fill_en      = 1'b0;
        log_en       = 1'b0;
        ld_res       = 1'b0;
        res_fault    = 1'b0;
        res_pa       = '0;
        case (state)
            ST_IDLE: if (req_valid) nxt = ST_LOOK;
            ST_LOOK: begin
                if (hit) begin
                    ld_res    = 1'b1;
                    res_fault = !perm_ok(hit_rd, hit_wr, cur_wr);
                    res_pa    = res_fault ? '0 : {hit_ppn, cur_iova[PAGE_SHIFT-1:0]};
                    log_en    = res_fault;
                    nxt       = ST_RESP;
                end else begin
                    tbl_rd_valid = 1'b1;
                    nxt          = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (tbl_rsp_valid) begin
                    ld_res    = 1'b1;
                    res_fault = !(ent_v && perm_ok(ent_r, ent_w, cur_wr));
                    res_pa    = res_fault ? '0 : {ent_ppn, cur_iova[PAGE_SHIFT-1:0]};
                    fill_en   = ent_v && !flush;
                    log_en    = res_fault;
                    nxt       = ST_RESP;
                end
            end
            ST_RESP: if (rsp_ready) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State, captured request and registered result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_dev  <= '0;
            cur_iova <= '0;
            cur_wr   <= 1'b0;
            cur_tid  <= '0;
            pa_q     <= '0;
            flt_q    <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && req_valid) begin
                cur_dev  <= req_dev;
                cur_iova <= req_iova;
                cur_wr   <= req_write;
                cur_tid  <= dev_map[req_dev*TID_W +: TID_W];
            end
            if (ld_res) begin
                pa_q  <= res_pa;
                flt_q <= res_fault;
            end
        end
    end

endmodule

// File: rtl/dxg_checker.sv
// Protocol checker for dma_xlate_guard, attached by bind.
// Assumes the table memory answers only after a strobe.
module dxg_checker #(
    parameter int PA_W = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [PA_W-1:0] rsp_pa,
    input logic            rsp_fault,
    input logic            tbl_rd_valid,
    input logic            fault_pulse
);
    // R11: a pending response is held unchanged until taken
    assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_fault));

    // R11: no new request accepted while a response is pending
    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R9: fault pulse lasts one cycle
    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |=> !fault_pulse);

    // R9: fault pulse coincides with a faulting response
    assert_pulse_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> rsp_valid && rsp_fault);

    // R4: a blocked access carries no address
    assert_fault_pa_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_pa == '0);

    // R7: one table read strobe per miss, never back to back
    assert_one_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_valid |=> !tbl_rd_valid && !rsp_valid);

endmodule

bind dma_xlate_guard dxg_checker #(.PA_W(PA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_pa       (rsp_pa),
    .rsp_fault    (rsp_fault),
    .tbl_rd_valid (tbl_rd_valid),
    .fault_pulse  (fault_pulse)
);

// File: tb/tb_dma_xlate_guard.sv
// Scoreboard bench for dma_xlate_guard.
module tb_dma_xlate_guard;
    localparam int NUM_DEV = 8, NUM_TBL = 4, IOVA_W = 20, PA_W = 24;
    localparam int DEV_W = 3, TID_W = 2, TAG_W = 10, ENT_W = 15;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                     rst_n = 1'b0;
    logic [NUM_DEV*TID_W-1:0] dev_map;
    logic                     flush = 1'b0;
    logic                     req_valid = 1'b0;
    logic                     req_ready;
    logic [DEV_W-1:0]         req_dev = '0;
    logic [IOVA_W-1:0]        req_iova = '0;
    logic                     req_write = 1'b0;
    logic                     rsp_valid;
    logic                     rsp_ready = 1'b1;
    logic [PA_W-1:0]          rsp_pa;
    logic                     rsp_fault;
    logic                     tbl_rd_valid;
    logic [TAG_W-1:0]         tbl_rd_addr;
    logic                     tbl_rsp_valid = 1'b0;
    logic [ENT_W-1:0]         tbl_rsp_data = '0;
    logic                     fault_pulse;
    logic [DEV_W-1:0]         fault_dev;
    logic [IOVA_W-1:0]        fault_addr;

    // dev0,dev1 -> table 0 (shared); dev2 -> 1; dev3..6 -> 2; dev7 -> 3
    assign dev_map = {2'd3, 2'd2, 2'd2, 2'd2, 2'd2, 2'd1, 2'd0, 2'd0};

    dma_xlate_guard dut (.*);

    int checks = 0, fails = 0;
    int tbl_reads = 0;
    int last_rd_addr = -1;
    int pulses = 0;
    int bp_cycles = 0;
    int wait_left = 0;
    logic [ENT_W-1:0] mem [1024];

    int    q_pa[$];
    bit    q_flt[$];
    string q_tag[$];

    function automatic logic [ENT_W-1:0] ent(bit v, bit r, bit w, logic [11:0] ppn);
        return {v, r, w, ppn};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Table memory model: answers each strobe two cycles later.
    int pend_cnt = 0;
    int pend_addr = 0;
    always @(negedge clk) begin
        tbl_rsp_valid <= 1'b0;
        if (pend_cnt > 0) begin
            pend_cnt <= pend_cnt - 1;
            if (pend_cnt == 1) begin
                tbl_rsp_valid <= 1'b1;
                tbl_rsp_data  <= mem[pend_addr];
            end
        end
        if (rst_n && tbl_rd_valid) begin
            tbl_reads    <= tbl_reads + 1;
            last_rd_addr <= int'(tbl_rd_addr);
            pend_addr    <= int'(tbl_rd_addr);
            pend_cnt     <= 2;
        end
        if (rst_n && fault_pulse) pulses <= pulses + 1;
    end

    // Monitor: applies back-pressure, then pops and compares each response.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (wait_left > 0) begin
                rsp_ready = 1'b0;
                wait_left--;
            end else begin
                rsp_ready = 1'b1;
                if (q_pa.size() == 0) begin
                    check(1'b0, "R11 unexpected response", int'(rsp_pa), 0);
                end else begin
                    automatic int    epa = q_pa.pop_front();
                    automatic bit    ef  = q_flt.pop_front();
                    automatic string tg  = q_tag.pop_front();
                    check(rsp_fault == ef, tg, int'(rsp_fault), int'(ef));
                    check(int'(rsp_pa) == epa, tg, int'(rsp_pa), epa);
                    check(req_ready == 1'b0, "R11 busy while responding", int'(req_ready), 0);
                end
            end
        end else if (!rsp_valid) begin
            rsp_ready = 1'b1;
            wait_left = bp_cycles;
        end
    end

    // Driver: queue expectation, send request, wait for result, check reads.
    task automatic send(int dev, int iova, bit wr, bit ef, int epa, int exp_reads,
                        int exp_addr, string tg);
        automatic int r0 = tbl_reads;
        q_pa.push_back(epa);
        q_flt.push_back(ef);
        q_tag.push_back(tg);
        @(negedge clk);
        req_valid = 1'b1;
        req_dev   = DEV_W'(dev);
        req_iova  = IOVA_W'(iova);
        req_write = wr;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (q_pa.size() != 0) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check(tbl_reads - r0 == exp_reads, {tg, " table reads"}, tbl_reads - r0, exp_reads);
        if (exp_addr >= 0)
            check(last_rd_addr == exp_addr, {tg, " table address"}, last_rd_addr, exp_addr);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    bit done = 1'b0;

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        mem[5]        = ent(1, 1, 1, 12'hA05);
        mem[256 + 5]  = ent(1, 1, 0, 12'h3C1);
        mem[6]        = ent(1, 1, 0, 12'h111);
        mem[7]        = ent(0, 1, 1, 12'h777);
        for (int i = 0; i < 9; i++) mem[768 + 16 + i] = ent(1, 1, 1, 12'(12'h800 + i));

        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
        check(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
        check(fault_pulse == 1'b0 && tbl_rd_valid == 1'b0, "R1 pulse/strobe",
              int'({fault_pulse, tbl_rd_valid}), 0);
        check(fault_dev == '0 && fault_addr == '0, "R1 fault status", int'(fault_addr), 0);
        rst_n = 1'b1;

        send(0, 'h05123, 0, 0, 'hA05123, 1, 5,   "R3 R7 miss translate");
        send(1, 'h05ABC, 0, 0, 'hA05ABC, 0, -1,  "R2 R6 shared table hit");
        send(2, 'h05ABC, 0, 0, 'h3C1ABC, 1, 261, "R2 separate table");
        send(2, 'h05000, 1, 1, 0,        0, -1,  "R4 R6 write denied on hit");
        check(fault_dev == 3'd2, "R9 fault_dev", int'(fault_dev), 2);
        check(fault_addr == 20'h05000, "R9 fault_addr", int'(fault_addr), 'h05000);
        send(0, 'h06010, 1, 1, 0,        1, 6,   "R4 write denied on miss");
        send(0, 'h06010, 0, 0, 'h111010, 0, -1,  "R4 R6 read allowed cached");
        send(0, 'h07000, 0, 1, 0,        1, 7,   "R5 invalid entry");
        mem[7] = ent(1, 1, 1, 12'h777);
        send(0, 'h07004, 0, 0, 'h777004, 1, 7,   "R12 invalid not cached");
        check(pulses == 3, "R9 pulse count", pulses, 3);

        mem[5] = ent(1, 1, 1, 12'hB05);
        bp_cycles = 3;
        send(0, 'h05000, 0, 0, 'hA05000, 0, -1,  "R8 R11 stale before flush");
        bp_cycles = 0;
        do_flush();
        send(1, 'h05000, 0, 0, 'hB05000, 1, 5,   "R8 refetch after flush");
        check(fault_dev == 3'd0 && fault_addr == 20'h07000, "R9 status held",
              int'(fault_addr), 'h07000);

        do_flush();
        for (int i = 0; i < 8; i++)
            send(7, (16 + i) << 12 | 'h004, 0, 0, (('h800 + i) << 12) | 'h004,
                 1, 768 + 16 + i, "R10 fill slots");
        send(7, 24 << 12, 0, 0, 'h808000, 1, 792, "R10 ninth page misses");
        send(7, 17 << 12, 0, 0, 'h801000, 0, -1,  "R10 second page kept");
        send(7, 16 << 12, 0, 0, 'h800000, 1, 784, "R10 first page evicted");
        check(pulses == 3, "R9 no extra pulses", pulses, 3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule